// File: doc/BRIEF.md
# Synchronous Rectifier Gate Timing Controller

This block decides, once per switching cycle, when the gate of a synchronous-rectifier switch is driven. Three comparator results arrive already digitized and synchronous to the clock. The first says the drain-source voltage has passed the turn-on level. The second says conduction has decayed to the turn-off level. The third says the drain-source voltage has swung past the arming level after conduction ended. An active-low `sync_n` input forces turn-off for continuous-conduction operation, and `run_en` gates the whole block.

Spurious comparator edges from ringing are kept out by two blanking windows. A minimum on-time starts at the gate's rising edge and masks turn-off detection while it runs. A minimum off-time starts when the arming comparator fires after the gate has fallen; until it expires the controller is not armed, so turn-on detection has no effect. Each armed cycle permits exactly one gate pulse. Both window lengths are given in clock cycles. If the off-time setting is flagged invalid, a built-in default of about 0.65 µs is used instead.

Top module: `sr_gate_ctrl`

## Requirements
- R1: The gate rises on the clock edge that samples `vds_on` high while the controller is armed, `sync_n` is high and the gate is low.
- R2: `sync_n` sampled low while the gate is high drops the gate at that same edge, even inside the minimum on-time window.
- R3: With `vds_off` held high, the gate stays high for exactly max(`ton_cycles`,1) cycles. `ton_cycles` is sampled at the rising edge.
- R4: The minimum off-time starts at the first edge that samples `vds_arm` high after the gate has fallen. The controller becomes armed max(`toff_cycles`,1) edges later, so the earliest rise comes one edge after that.
- R5: A turn-on request held before arming is delayed. The gate rises on the first edge where the controller is armed.
- R6: While `sync_n` is held low the gate stays low, even if the controller is armed and `vds_on` is high. The gate rises on the edge that first samples `sync_n` high again.
- R7: When `toff_valid` is low, the minimum off-time is TOFF_DEFAULT cycles (33 by default) and `toff_cycles` is ignored.
- R8: A `ton_cycles` or `toff_cycles` value of zero acts as one cycle.
- R9: `run_en` low forces `gate` low in the same cycle, clears the armed state and aborts both timers. After re-enable, a new `vds_arm` crossing is needed before any turn-on.
- R10: Only one gate pulse occurs per armed cycle. After the gate falls, a `vds_on` that is still high does not turn it on again.
- R11: `cond_start` is high only in the first gate-high cycle. `cond_end` is high only in the first cycle after a threshold or SYNC turn-off. The two are never high together.
- R12: After reset, `gate`, `cond_start` and `cond_end` are low and the controller is unarmed but waiting for an arming crossing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Run enable; low forces the gate off and disarms the controller |
| vds_on | input | 1 | Drain-source voltage beyond the turn-on level |
| vds_off | input | 1 | Drain-source voltage back at the turn-off level |
| vds_arm | input | 1 | Drain-source voltage past the arming level |
| sync_n | input | 1 | Active-low external turn-off; held low keeps the gate off |
| ton_cycles | input | CNT_W | Minimum on-time in clock cycles |
| toff_cycles | input | CNT_W | Minimum off-time in clock cycles |
| toff_valid | input | 1 | Off-time setting is valid; low selects the default |
| gate | output | 1 | Gate drive |
| cond_start | output | 1 | One-cycle strobe in the first gate-high cycle |
| cond_end | output | 1 | One-cycle strobe after a threshold or SYNC turn-off |

## Verification
The assertions assume the comparator inputs and `sync_n` are already synchronous to `clk`. They also assume `ton_cycles` is meaningful at the edge where the gate rises, since the on-time check captures it there. The stimulus changes every input shortly after a rising edge and holds `ton_cycles` constant through each pulse. It drives `run_en` low only between or inside whole cycles, never as a glitch. Turn-on requests are raised early on purpose, so that the off-time window, not the request, sets when the gate rises.

// File: rtl/sr_gate_ctrl.sv
module sr_gate_ctrl #(
  parameter int CNT_W        = 12,
  parameter int TOFF_DEFAULT = 33
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic             vds_on,
  input  logic             vds_off,
  input  logic             vds_arm,
  input  logic             sync_n,
  input  logic [CNT_W-1:0] ton_cycles,
  input  logic [CNT_W-1:0] toff_cycles,
  input  logic             toff_valid,
  output logic             gate,
  output logic             cond_start,
  output logic             cond_end
);

  localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);
  localparam logic [CNT_W-1:0] TOFF_DEF = CNT_W'(TOFF_DEFAULT);

  logic             gate_q, armed, wait_arm, off_run, start_q, end_q;
  logic [CNT_W-1:0] on_cnt, off_cnt;

  wire [CNT_W-1:0] ton_eff  = (ton_cycles == '0) ? ONE : ton_cycles;
  wire [CNT_W-1:0] toff_eff = !toff_valid ? TOFF_DEF
                            : ((toff_cycles == '0) ? ONE : toff_cycles);

  wire on_done  = on_cnt <= ONE;
  wire turn_on  = !gate_q && armed && vds_on && sync_n;
  wire turn_off = gate_q && (!sync_n || (vds_off && on_done));
  wire arm_hit  = wait_arm && vds_arm && !gate_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_q   <= 1'b0;
      armed    <= 1'b0;
      wait_arm <= 1'b1;
      off_run  <= 1'b0;
      start_q  <= 1'b0;
      end_q    <= 1'b0;
      on_cnt   <= '0;
      off_cnt  <= '0;
    end else if (!run_en) begin
      gate_q   <= 1'b0;
      armed    <= 1'b0;
      wait_arm <= 1'b1;
      off_run  <= 1'b0;
      start_q  <= 1'b0;
      end_q    <= 1'b0;
      on_cnt   <= '0;
      off_cnt  <= '0;
    end else begin
      start_q <= turn_on;
      end_q   <= turn_off;

      if (turn_on) begin
        gate_q <= 1'b1;
        armed  <= 1'b0;
        on_cnt <= ton_eff;
      end else if (turn_off) begin
        gate_q   <= 1'b0;
        wait_arm <= 1'b1;
      end else if (gate_q && !on_done) begin
        on_cnt <= on_cnt - ONE;
      end

      if (arm_hit) begin
        off_run  <= 1'b1;
        off_cnt  <= toff_eff;
        wait_arm <= 1'b0;
      end else if (off_run) begin
        if (off_cnt <= ONE) begin
          off_run <= 1'b0;
          armed   <= 1'b1;
        end else begin
          off_cnt <= off_cnt - ONE;
        end
      end
    end
  end

  assign gate       = gate_q & run_en;
  assign cond_start = start_q;
  assign cond_end   = end_q;

endmodule

// File: rtl/sr_gate_ctrl_chk.sv
module sr_gate_ctrl_chk #(
  parameter int CNT_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run_en,
  input logic             sync_n,
  input logic             vds_on,
  input logic [CNT_W-1:0] ton_cycles,
  input logic             gate,
  input logic             cond_start,
  input logic             cond_end
);

  logic             gate_d, sync_d, run_d;
  logic [CNT_W-1:0] ton_d, need;
  logic [CNT_W:0]   hi_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_d <= 1'b0;
      sync_d <= 1'b1;
      run_d  <= 1'b0;
      ton_d  <= '0;
      need   <= '0;
      hi_len <= '0;
    end else begin
      gate_d <= gate;
      sync_d <= sync_n;
      run_d  <= run_en;
      ton_d  <= ton_cycles;
      if (gate && !gate_d) begin
        hi_len <= (CNT_W+1)'(1);
        need   <= (ton_d == '0) ? CNT_W'(1) : ton_d;
      end else if (gate && hi_len != '1) begin
        hi_len <= hi_len + (CNT_W+1)'(1);
      end
    end
  end

  assert_rise_cause_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate) |-> ($past(vds_on) && $past(sync_n)));

  assert_sync_kill_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_n |=> !gate);

  assert_min_on_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_d && !gate && sync_d && run_d && run_en) |-> (hi_len >= {1'b0, need}));

  assert_gate_needs_run_R9: assert property (@(posedge clk) disable iff (!rst_n)
    gate |-> run_en);

  assert_strobe_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cond_start, cond_end}));

endmodule

bind sr_gate_ctrl sr_gate_ctrl_chk #(.CNT_W(CNT_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .run_en    (run_en),
  .sync_n    (sync_n),
  .vds_on    (vds_on),
  .ton_cycles(ton_cycles),
  .gate      (gate),
  .cond_start(cond_start),
  .cond_end  (cond_end)
);

// File: tb/sr_gate_ctrl_tb_top.sv
module sr_gate_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 12;
  localparam int TOFF_DEF   = 33;

  logic clk = 1'b0, rst_n = 1'b0, run_en = 1'b0;
  logic vds_on = 1'b0, vds_off = 1'b0, vds_arm = 1'b0, sync_n = 1'b1;
  logic [CNT_W-1:0] ton_cycles = '0, toff_cycles = '0;
  logic toff_valid = 1'b1;
  logic gate, cond_start, cond_end;

  sr_gate_ctrl #(.CNT_W(CNT_W), .TOFF_DEFAULT(TOFF_DEF)) dut_i (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .vds_on(vds_on),
    .vds_off(vds_off), .vds_arm(vds_arm), .sync_n(sync_n),
    .ton_cycles(ton_cycles), .toff_cycles(toff_cycles),
    .toff_valid(toff_valid), .gate(gate), .cond_start(cond_start),
    .cond_end(cond_end)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    int    cyc;
    int    sel;
    logic  val;
    string tag;
  } exp_t;

  exp_t exp_q[$];
  int   cyc = 0;
  int   vectors = 0;
  int   fails = 0;
  bit   done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    while (exp_q.size() > 0 && exp_q[0].cyc <= cyc) begin
      automatic exp_t e = exp_q.pop_front();
      automatic logic act = (e.sel == 0) ? gate : (e.sel == 1) ? cond_start : cond_end;
      vectors++;
      if (e.cyc != cyc || act !== e.val) begin
        fails++;
        $display("FAIL %s sig%0d cycle %0d: actual %b expected %b", e.tag, e.sel, e.cyc, act, e.val);
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic expect_at(input int off, input int sel, input logic v, input string tag);
    exp_q.push_back('{cyc + off, sel, v, tag});
  endtask

  task automatic idle_inputs();
    vds_on = 1'b0; vds_off = 1'b0; vds_arm = 1'b0;
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    expect_at(0, 0, 1'b0, "R12 gate");
    expect_at(0, 1, 1'b0, "R12 cond_start");
    expect_at(0, 2, 1'b0, "R12 cond_end");
    step(2);

    // A: basic pulse, arming delay, blanking, one pulse per arm
    run_en = 1'b1; ton_cycles = 4; toff_cycles = 3; toff_valid = 1'b1;
    vds_on = 1'b1; vds_off = 1'b1; vds_arm = 1'b1;
    expect_at(4, 0, 1'b0, "R5 held before arm");
    expect_at(5, 0, 1'b1, "R4 rise after off-time");
    expect_at(5, 1, 1'b1, "R11 start strobe");
    expect_at(6, 1, 1'b0, "R11 start strobe width");
    expect_at(8, 0, 1'b1, "R3 blanked");
    expect_at(9, 0, 1'b0, "R3 fall at min on");
    expect_at(9, 2, 1'b1, "R11 end strobe");
    expect_at(10, 2, 1'b0, "R11 end strobe width");
    expect_at(12, 0, 1'b0, "R10 no second pulse");
    step(1); vds_arm = 1'b0;
    step(13); idle_inputs();
    step(1);

    // B: SYNC kill and SYNC held low
    ton_cycles = 6; toff_cycles = 2; vds_arm = 1'b1; vds_on = 1'b1;
    expect_at(3, 0, 1'b0, "R4 not yet armed");
    expect_at(4, 0, 1'b1, "R1 rise");
    step(1); vds_arm = 1'b0;
    step(5); sync_n = 1'b0;
    expect_at(0, 0, 1'b1, "R2 before sync");
    expect_at(1, 0, 1'b0, "R2 sync overrides blanking");
    expect_at(1, 2, 1'b1, "R11 end on sync");
    step(2); vds_arm = 1'b1;
    expect_at(6, 0, 1'b0, "R6 held low");
    expect_at(12, 0, 1'b0, "R6 held low late");
    step(1); vds_arm = 1'b0;
    step(12); sync_n = 1'b1;
    expect_at(0, 0, 1'b0, "R6 before release");
    expect_at(1, 0, 1'b1, "R6 rise on release");
    step(1); vds_off = 1'b1;
    expect_at(5, 0, 1'b1, "R3 ton=6 blanked");
    expect_at(6, 0, 1'b0, "R3 ton=6 fall");
    step(8); idle_inputs();
    step(1);

    // C: default off-time and zero on-time
    toff_valid = 1'b0; toff_cycles = 2; ton_cycles = 0;
    vds_arm = 1'b1; vds_on = 1'b1; vds_off = 1'b1;
    expect_at(TOFF_DEF + 1, 0, 1'b0, "R7 default off-time");
    expect_at(TOFF_DEF + 2, 0, 1'b1, "R7 rise after default");
    expect_at(TOFF_DEF + 3, 0, 1'b0, "R8 ton zero one cycle");
    step(1); vds_arm = 1'b0;
    step(TOFF_DEF + 6); idle_inputs();
    step(1);

    // D: zero off-time
    toff_valid = 1'b1; toff_cycles = 0; ton_cycles = 2;
    vds_arm = 1'b1; vds_on = 1'b1; vds_off = 1'b1;
    expect_at(2, 0, 1'b0, "R8 toff zero not yet");
    expect_at(3, 0, 1'b1, "R8 toff zero rise");
    expect_at(4, 0, 1'b1, "R3 ton=2");
    expect_at(5, 0, 1'b0, "R3 ton=2 fall");
    step(1); vds_arm = 1'b0;
    step(8); idle_inputs();
    step(1);

    // E: run enable drop during a pulse
    ton_cycles = 10; toff_cycles = 2; vds_arm = 1'b1; vds_on = 1'b1;
    expect_at(4, 0, 1'b1, "R1 rise E");
    expect_at(5, 0, 1'b1, "R9 before drop");
    step(1); vds_arm = 1'b0;
    step(5); run_en = 1'b0;
    expect_at(0, 0, 1'b0, "R9 immediate off");
    step(3); run_en = 1'b1;
    expect_at(6, 0, 1'b0, "R9 disarmed after enable");
    step(7); vds_arm = 1'b1;
    expect_at(3, 0, 1'b0, "R9 rearm wait");
    expect_at(4, 0, 1'b1, "R9 rise after rearm");
    step(1); vds_arm = 1'b0;
    step(4); vds_off = 1'b1;
    expect_at(8, 0, 1'b1, "R3 ton=10 blanked");
    expect_at(9, 0, 1'b0, "R3 ton=10 fall");
    step(12); idle_inputs();
    step(1);

    // F: run enable drop aborts the off-time timer
    ton_cycles = 1; toff_cycles = 5; vds_arm = 1'b1; vds_on = 1'b1; vds_off = 1'b1;
    step(1); vds_arm = 1'b0;
    step(1); run_en = 1'b0;
    step(1); run_en = 1'b1;
    expect_at(4, 0, 1'b0, "R9 timer aborted");
    expect_at(7, 0, 1'b0, "R9 timer aborted late");
    step(8); vds_arm = 1'b1;
    expect_at(6, 0, 1'b0, "R4 toff=5 wait");
    expect_at(7, 0, 1'b1, "R4 toff=5 rise");
    expect_at(8, 0, 1'b0, "R3 ton=1 fall");
    step(1); vds_arm = 1'b0;
    step(10); idle_inputs();

    while (exp_q.size() > 0) step(1);
    step(2);
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule